// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit resolves two-byte relative branches for a small 8-bit processor core. Each issued branch is given as an opcode byte, the four arithmetic flags (negative, zero, overflow, carry), an 8-bit signed displacement and the address of the branch instruction. The unit decides whether the branch is taken and supplies the address the core should fetch next.

Six opcodes are recognised. Three test flags directly: carry clear, carry set and zero set. One tests the unsigned "higher" condition built from carry and zero. Two test signed conditions built from negative XOR overflow. A taken branch continues at the address of the following instruction plus the sign-extended displacement. A branch that is not taken continues at the following instruction. Any other opcode is reported as illegal and is never taken. The unit never changes a flag. Results are registered and appear one clock after an issue strobe.

Top module: `brdu_top`

## Requirements
- R1: After reset is released, `res_vld`, `taken` and `illegal` are 0 and `next_pc` is 0x0000 until the first issue is captured.
- R2: Opcode 0x24 is taken exactly when C = 0, and opcode 0x25 is taken exactly when C = 1.
- R3: Opcode 0x27 is taken exactly when Z = 1.
- R4: Opcode 0x2C is taken exactly when (N XOR V) = 0.
- R5: Opcode 0x2E is taken exactly when (Z OR (N XOR V)) = 0.
- R6: Opcode 0x22 is taken exactly when (C OR Z) = 0.
- R7: When a branch is taken, `next_pc` = pc + 2 + sign_extend(disp), modulo 2^16. Bit 7 of `disp` is its sign bit.
- R8: When a recognised branch is not taken, `next_pc` = pc + 2, modulo 2^16.
- R9: Every opcode outside {0x22, 0x24, 0x25, 0x27, 0x2C, 0x2E} gives `illegal` = 1, `taken` = 0 and `next_pc` = pc + 2. A recognised opcode gives `illegal` = 0.
- R10: Inputs are captured on a rising edge where `dec_en` = 1. `res_vld` is 1 in the following cycle only. After an edge where `dec_en` = 0, `res_vld` is 0 and `taken`, `illegal` and `next_pc` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_en | input | 1 | Issue strobe; inputs are captured when high |
| opcode | input | 8 | Branch opcode byte |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| disp | input | 8 | Signed branch displacement |
| pc | input | 16 | Address of the branch opcode |
| res_vld | output | 1 | Result registered this cycle |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Opcode is not a supported branch |
| next_pc | output | 16 | Address to fetch next |

## Verification
Two things can happen in the same cycle: a taken decision and a carry out of the 16-bit target adder, which wraps the address through zero. The bench issues taken branches from addresses near 0xFFFF with forward displacements, and from addresses near 0x0000 with backward displacements. For each it checks the taken bit and the wrapped target against an independent model. An illegal opcode issued with flags that would satisfy every condition also shares a cycle with the decision. The bench checks that `illegal` wins, that `taken` stays low and that the sequential address is returned.

// File: rtl/brdu_pkg.sv
package brdu_pkg;

  typedef enum logic [2:0] {
    COND_NONE   = 3'd0,
    COND_C_CLR  = 3'd1,
    COND_C_SET  = 3'd2,
    COND_Z_SET  = 3'd3,
    COND_S_GE   = 3'd4,
    COND_S_GT   = 3'd5,
    COND_U_HI   = 3'd6
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam logic [7:0] OP_U_HI  = 8'h22;
  localparam logic [7:0] OP_C_CLR = 8'h24;
  localparam logic [7:0] OP_C_SET = 8'h25;
  localparam logic [7:0] OP_Z_SET = 8'h27;
  localparam logic [7:0] OP_S_GE  = 8'h2C;
  localparam logic [7:0] OP_S_GT  = 8'h2E;

endpackage

// File: rtl/brdu_rst_sync.sv
module brdu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/brdu_cond_decode.sv
module brdu_cond_decode
  import brdu_pkg::*;
(
  input  logic [7:0] opcode,
  output cond_e      cond,
  output logic       legal
);
  always_comb begin
    cond  = COND_NONE;
    legal = 1'b1;
    unique case (opcode)
      OP_U_HI:  cond = COND_U_HI;
      OP_C_CLR: cond = COND_C_CLR;
      OP_C_SET: cond = COND_C_SET;
      OP_Z_SET: cond = COND_Z_SET;
      OP_S_GE:  cond = COND_S_GE;
      OP_S_GT:  cond = COND_S_GT;
      default: begin
        cond  = COND_NONE;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/brdu_cond_eval.sv
module brdu_cond_eval
  import brdu_pkg::*;
(
  input  cond_e  cond,
  input  flags_t flags,
  output logic   take
);
  logic sgn_lt;

  assign sgn_lt = flags.n ^ flags.v;

  always_comb begin
    unique case (cond)
      COND_C_CLR: take = ~flags.c;
      COND_C_SET: take =  flags.c;
      COND_Z_SET: take =  flags.z;
      COND_S_GE:  take = ~sgn_lt;
      COND_S_GT:  take = ~(flags.z | sgn_lt);
      COND_U_HI:  take = ~(flags.c | flags.z);
      default:    take = 1'b0;
    endcase
  end
endmodule

// File: rtl/brdu_target_calc.sv
module brdu_target_calc #(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] tgt_pc
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign seq_pc   = pc + STEP;
  assign tgt_pc   = seq_pc + disp_ext;
endmodule

// File: rtl/brdu_top.sv
module brdu_top
  import brdu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic [7:0]        opcode,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] pc,
  output logic              res_vld,
  output logic              taken,
  output logic              illegal,
  output logic [ADDR_W-1:0] next_pc
);
  logic              rst_sync_n;
  cond_e             cond;
  logic              legal;
  logic              take_raw;
  flags_t            flags;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;

  logic              vld_d;
  logic              taken_d;
  logic              illegal_d;
  logic [ADDR_W-1:0] npc_d;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brdu_rst_sync #(.STAGES(SYNC_STG)) rst_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (rst_sync_n)
  );

  brdu_cond_decode decode_i (
    .opcode (opcode),
    .cond   (cond),
    .legal  (legal)
  );

  brdu_cond_eval eval_i (
    .cond  (cond),
    .flags (flags),
    .take  (take_raw)
  );

  brdu_target_calc #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .INSN_BYTES (INSN_BYTES)
  ) target_i (
    .pc     (pc),
    .disp   (disp),
    .seq_pc (seq_pc),
    .tgt_pc (tgt_pc)
  );

  // next-state
  always_comb begin
    vld_d     = dec_en;
    taken_d   = taken;
    illegal_d = illegal;
    npc_d     = next_pc;
    if (dec_en) begin
      taken_d   = take_raw & legal;
      illegal_d = ~legal;
      npc_d     = (take_raw & legal) ? tgt_pc : seq_pc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_vld <= 1'b0;
      taken   <= 1'b0;
      illegal <= 1'b0;
      next_pc <= '0;
    end else begin
      res_vld <= vld_d;
      if (dec_en) begin
        taken   <= taken_d;
        illegal <= illegal_d;
        next_pc <= npc_d;
      end
    end
  end
endmodule

// File: rtl/brdu_chk.sv
module brdu_chk #(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input logic              clk,
  input logic              srst_n,
  input logic              dec_en,
  input logic [7:0]        opcode,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic [DISP_W-1:0] disp,
  input logic [ADDR_W-1:0] pc,
  input logic              res_vld,
  input logic              taken,
  input logic              illegal,
  input logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic              armed;
  logic              p_en;
  logic [7:0]        p_op;
  logic              p_z;
  logic              p_c;
  logic [DISP_W-1:0] p_disp;
  logic [ADDR_W-1:0] p_pc;
  logic [ADDR_W-1:0] p_seq;
  logic [ADDR_W-1:0] p_tgt;
  logic              p_flag_n;
  logic              p_flag_v;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed    <= 1'b0;
      p_en     <= 1'b0;
      p_op     <= '0;
      p_z      <= 1'b0;
      p_c      <= 1'b0;
      p_flag_n <= 1'b0;
      p_flag_v <= 1'b0;
      p_disp   <= '0;
      p_pc     <= '0;
    end else begin
      armed    <= 1'b1;
      p_en     <= dec_en;
      p_op     <= opcode;
      p_z      <= flag_z;
      p_c      <= flag_c;
      p_flag_n <= flag_n;
      p_flag_v <= flag_v;
      p_disp   <= disp;
      p_pc     <= pc;
    end
  end

  assign p_seq = p_pc + STEP;
  assign p_tgt = p_seq + {{(ADDR_W-DISP_W){p_disp[DISP_W-1]}}, p_disp};

  // R10
  vld_follows_issue_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    res_vld == p_en);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !dec_en |=> ($stable(taken) && $stable(illegal) && $stable(next_pc)));

  // R9
  illegal_not_taken_chk: assert property (@(posedge clk) disable iff (!srst_n)
    illegal |-> !taken);

  // R8
  seq_addr_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && !taken) |-> next_pc == p_seq);

  // R7
  target_addr_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && taken) |-> next_pc == p_tgt);

  // R2
  carry_cond_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && (p_op == 8'h24 || p_op == 8'h25)) |-> taken == (p_c == p_op[0]));

  // R3
  zero_cond_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && p_op == 8'h27) |-> taken == p_z);

  // R4
  sge_cond_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && p_op == 8'h2C) |-> taken == (p_flag_n == p_flag_v));

  // R5
  sgt_cond_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && p_op == 8'h2E) |-> taken == (!p_z && (p_flag_n == p_flag_v)));

  // R6
  uhi_cond_chk: assert property (@(posedge clk) disable iff (!srst_n || !armed)
    (res_vld && p_op == 8'h22) |-> taken == (!p_c && !p_z));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !armed |-> (!res_vld && !taken && !illegal && next_pc == '0));
endmodule

bind brdu_top brdu_chk #(
  .ADDR_W     (ADDR_W),
  .DISP_W     (DISP_W),
  .INSN_BYTES (INSN_BYTES)
) chk_i (
  .clk     (clk),
  .srst_n  (rst_sync_n),
  .dec_en  (dec_en),
  .opcode  (opcode),
  .flag_n  (flag_n),
  .flag_z  (flag_z),
  .flag_v  (flag_v),
  .flag_c  (flag_c),
  .disp    (disp),
  .pc      (pc),
  .res_vld (res_vld),
  .taken   (taken),
  .illegal (illegal),
  .next_pc (next_pc)
);

// File: tb/brdu_tb_top.sv
`timescale 1ns/1ps
module brdu_top_tb_top;
  typedef struct {
    logic        tk;
    logic        il;
    logic [15:0] npc;
    logic [7:0]  op;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_en;
  logic [7:0]  opcode;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [7:0]  disp;
  logic [15:0] pc;
  logic        res_vld, taken, illegal;
  logic [15:0] next_pc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  brdu_top dut_i (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .opcode(opcode),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .disp(disp), .pc(pc), .res_vld(res_vld), .taken(taken),
    .illegal(illegal), .next_pc(next_pc)
  );

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h24, 8'h25: return "R2";
      8'h27:        return "R3";
      8'h2C:        return "R4";
      8'h2E:        return "R5";
      8'h22:        return "R6";
      default:      return "R9";
    endcase
  endfunction

  task automatic issue(input logic [7:0] op, input logic [3:0] nzvc,
                       input logic [15:0] a, input logic [7:0] d);
    exp_t e;
    logic n, z, v, c, ok, tk;
    {n, z, v, c} = nzvc;
    ok = 1'b1;
    case (op)
      8'h24: tk = !c;
      8'h25: tk = c;
      8'h27: tk = z;
      8'h2C: tk = !(n ^ v);
      8'h2E: tk = !(z | (n ^ v));
      8'h22: tk = !(c | z);
      default: begin tk = 1'b0; ok = 1'b0; end
    endcase
    e.tk  = tk;
    e.il  = !ok;
    e.op  = op;
    e.npc = tk ? (a + 16'd2 + {{8{d[7]}}, d}) : (a + 16'd2);
    @(negedge clk);
    dec_en = 1'b1; opcode = op; {flag_n, flag_z, flag_v, flag_c} = nzvc;
    pc = a; disp = d;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    dec_en = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R10: result with no issue pending (res_vld=%b exp=0)", res_vld);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (taken !== e.tk || illegal !== e.il || next_pc !== e.npc) begin
          errors++;
          $display("FAIL %s/%s op=%h: taken=%b illegal=%b next_pc=%h, expected taken=%b illegal=%b next_pc=%h",
                   req_of(e.op), e.tk ? "R7" : "R8", e.op, taken, illegal, next_pc,
                   e.tk, e.il, e.npc);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R10: watchdog expired (cycles=%0d expected<100000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [6];
    ops = '{8'h22, 8'h24, 8'h25, 8'h27, 8'h2C, 8'h2E};
    rst_n = 1'b0; dec_en = 1'b0; opcode = '0; disp = '0; pc = '0;
    {flag_n, flag_z, flag_v, flag_c} = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    checks++;
    if (res_vld !== 1'b0 || taken !== 1'b0 || illegal !== 1'b0 || next_pc !== 16'h0000) begin
      errors++;
      $display("FAIL R1: vld=%b taken=%b illegal=%b next_pc=%h, expected 0 0 0 0000",
               res_vld, taken, illegal, next_pc);
    end

    // R2..R6: every condition under every flag combination
    foreach (ops[i]) begin
      for (int f = 0; f < 16; f++) issue(ops[i], 4'(f), 16'h4000 + 16'(f * 8), 8'h10);
    end
    idle();

    // R9: full opcode sweep, all flags set and all clear
    for (int o = 0; o < 256; o++) begin
      issue(8'(o), 4'hF, 16'h2000, 8'h7F);
      issue(8'(o), 4'h0, 16'hFFFF, 8'h80);
    end
    idle();

    // R7 / R8 wrap corner cases
    issue(8'h27, 4'b0100, 16'hFFFE, 8'h01); // R7 taken, forward wrap -> 0001
    issue(8'h27, 4'b0100, 16'h0000, 8'h80); // R7 taken, backward wrap -> FF82
    issue(8'h25, 4'b0001, 16'hFF80, 8'h7F); // R7 taken max forward -> 0001
    issue(8'h24, 4'b0001, 16'hFFFF, 8'h40); // R8 not taken wrap -> 0001
    issue(8'h2C, 4'b1000, 16'hFFFE, 8'hFE); // R8 not taken -> 0000
    issue(8'h22, 4'b0000, 16'h0100, 8'hFE); // R7 branch to self -> 0100
    idle();

    // R10 hold: issue then idle with changed inputs
    issue(8'h27, 4'b0100, 16'h1000, 8'h10); // expect taken, 1012
    @(negedge clk);
    dec_en = 1'b0; opcode = 8'h00; pc = 16'h5555; disp = 8'hAA;
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || taken !== 1'b1 || illegal !== 1'b0 || next_pc !== 16'h1012) begin
      errors++;
      $display("FAIL R10: vld=%b taken=%b illegal=%b next_pc=%h, expected 0 1 0 1012",
               res_vld, taken, illegal, next_pc);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d results missing, expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule